// File: doc/BRIEF.md
# Bus-Master DMA Channel Register File

This block holds the software-visible control state of one channel of a bus-master disk DMA engine. A byte-addressable register bus, with accesses of 1, 2 or 4 bytes at any byte offset, reaches three registers. A command register holds a start bit and a transfer-direction bit. A status register reports whether the channel is active, whether an error occurred, and whether the drive has interrupted. A 32-bit register holds the base address of the descriptor table.

The block does not move data. A separate descriptor walker does that, and this block tells it what to do through one-cycle strobes. A cancel strobe stops the walker. A load strobe, together with a pointer value, resets the walker's current descriptor pointer to the table base. A kick strobe resumes a transfer that the walker is holding. A flush strobe tells the walker to clear its current length and last-descriptor state after a reset. The drive's interrupt line passes straight through to the interrupt output. Each rising edge of that line also latches a sticky status bit, which software clears.

Top module: `dma_chan_regs`

## Requirements
- R1: The command register sits at byte offset 0. It stores bit 0 (start) and bit 3 (direction) and reads every other bit as zero. `dir_o` mirrors the stored direction bit.
- R2: A command write whose start bit equals the stored start bit produces no strobe and leaves the active bit unchanged. It still updates the direction bit.
- R3: A command write that changes start from 1 to 0 raises `walk_cancel_o` for one cycle, in the cycle after the write, and clears the active bit.
- R4: A command write that changes start from 0 to 1 raises `walk_load_o` for one cycle, in the cycle after the write. In that cycle `walk_ptr_o` holds the table base as it was at the write.
- R5: On a 0-to-1 start change, if the channel is not active, the active bit is set. `walk_kick_o` then pulses together with the load strobe when `walk_pending_i` was high at the write.
- R6: A high `walk_end_i` clears the active bit. A high `walk_err_i` sets the error bit.
- R7: The status register sits at byte offset 2, with bit 0 = active, bit 1 = error and bit 2 = interrupt; all other bits read as zero. Writing 1 to bit 1 or bit 2 clears that bit. The bus cannot write bit 0.
- R8: A rising edge of `drv_irq_i` sets the interrupt bit, and this set wins over a clear in the same cycle. A falling edge keeps the bit. `irq_o` equals `drv_irq_i` in the same cycle.
- R9: The table base sits at byte offsets 4 to 7, least significant byte first. A write replaces only the byte lanes it covers. Write data is aligned to the least significant byte, so data byte k lands at offset `bus_off`+k. Bits 1:0 of the base always read as zero.
- R10: `bus_size` encodes 0 = 1 byte, 1 = 2 bytes, and 2 or 3 = 4 bytes. `bus_rdata` byte k holds the register byte at offset `bus_off`+k when k is below the access width and that offset is at most 7. Every other read byte is zero, including offsets 1 and 3.
- R11: A reset cycle clears command, status, base and walker pointer. It pulses `walk_cancel_o` in the next cycle if the channel was active, and raises `walk_flush_o` in the cycle after each reset cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write in this cycle |
| bus_off | input | 3 | Byte offset of the access |
| bus_size | input | 2 | Access width code |
| bus_wdata | input | 32 | Write data, LSB-aligned |
| bus_rdata | output | 32 | Read data for the current offset and width |
| walk_pending_i | input | 1 | Walker holds a transfer waiting for start |
| walk_end_i | input | 1 | Walker finished; clear active |
| walk_err_i | input | 1 | Walker reports an error |
| walk_cancel_o | output | 1 | Cancel strobe |
| walk_load_o | output | 1 | Descriptor pointer reload strobe |
| walk_kick_o | output | 1 | Resume pending transfer strobe |
| walk_flush_o | output | 1 | Clear walker progress after reset |
| walk_ptr_o | output | 32 | Reloaded descriptor pointer |
| dir_o | output | 1 | Stored direction bit |
| drv_irq_i | input | 1 | Drive interrupt line |
| irq_o | output | 1 | Interrupt output, follows the drive line |

## Verification
Some properties are checked by assertions on every cycle. These are: the two walker strobes never fire together, a cancel always leaves the channel inactive, a load always carries the base from the cycle before, a write with no change to start is quiet, the base never shows nonzero low bits, and a rising drive interrupt always leaves the status bit set. Other behaviour can only be shown by the bench's scenarios. That covers the lane mapping of mixed-width writes at odd offsets, the zeroing of reads that run past offset 7, the kick depending on the pending input, a rising interrupt winning over a clear in the same cycle, and the cancel issued when reset hits an active channel.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
    localparam int LANES      = 8;
    localparam int IMG_W      = LANES * 8;
    localparam int BUS_BYTES  = 4;
    localparam int BUS_W      = BUS_BYTES * 8;
    localparam int CMD_LANE   = 0;
    localparam int STAT_LANE  = 2;
    localparam int BASE_LANE  = 4;
    localparam int BASE_BYTES = 4;
    localparam int BASE_W     = BASE_BYTES * 8;
    localparam logic [7:0] CMD_KEEP = 8'h09;
    localparam int ST_ACT = 0;
    localparam int ST_ERR = 1;
    localparam int ST_IRQ = 2;

    typedef struct packed {
        logic cancel;
        logic load;
        logic kick;
    } walk_strobe_t;

    function automatic logic [3:0] access_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd1;
            2'd1:    return 4'd2;
            default: return 4'd4;
        endcase
    endfunction
endpackage

// File: rtl/bmr_lane_map.sv
module bmr_lane_map
    import bmr_pkg::*;
(
    input  logic             wr_i,
    input  logic [2:0]       off_i,
    input  logic [1:0]       size_i,
    input  logic [BUS_W-1:0] wdata_i,
    input  logic [IMG_W-1:0] img_i,
    output logic [LANES-1:0] we_o,
    output logic [IMG_W-1:0] wb_o,
    output logic [BUS_W-1:0] rdata_o
);
    logic [3:0] nbytes, first, past_end;
    assign nbytes   = access_bytes(size_i);
    assign first    = {1'b0, off_i};
    assign past_end = first + nbytes;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_wlane
            localparam logic [3:0] LI = 4'(i);
            logic [1:0] rel;
            assign rel = 2'(LI - first);
            assign we_o[i] = wr_i && (LI >= first) && (LI < past_end);
            assign wb_o[i*8 +: 8] = wdata_i[{rel, 3'b000} +: 8];
        end
        for (genvar j = 0; j < BUS_BYTES; j++) begin : g_rlane
            localparam logic [3:0] LJ = 4'(j);
            logic [3:0] src;
            assign src = first + LJ;
            assign rdata_o[j*8 +: 8] = (LJ < nbytes && !src[3]) ?
                                       img_i[{src[2:0], 3'b000} +: 8] : 8'h00;
        end
    endgenerate
endmodule

// File: rtl/bmr_cmd_ctrl.sv
module bmr_cmd_ctrl
    import bmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [7:0]        wb_i,
    input  logic [BASE_W-1:0] base_i,
    input  logic              pending_i,
    input  logic              end_i,
    output logic [7:0]        cmd_o,
    output logic              active_o,
    output walk_strobe_t      strobe_o,
    output logic              flush_o,
    output logic [BASE_W-1:0] ptr_o
);
    logic         toggle;
    logic         act_n;
    walk_strobe_t strb_n;

    assign toggle = we_i && (wb_i[0] != cmd_o[0]);

    always_comb begin
        act_n  = active_o;
        strb_n = '0;
        if (toggle && !wb_i[0]) begin
            strb_n.cancel = 1'b1;
            act_n         = 1'b0;
        end else if (toggle) begin
            strb_n.load = 1'b1;
            if (!active_o) begin
                act_n       = 1'b1;
                strb_n.kick = pending_i;
            end
        end else if (end_i) begin
            act_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_o    <= '0;
            active_o <= 1'b0;
            ptr_o    <= '0;
            strobe_o <= '{cancel: active_o, load: 1'b0, kick: 1'b0};
            flush_o  <= 1'b1;
        end else begin
            flush_o  <= 1'b0;
            strobe_o <= strb_n;
            active_o <= act_n;
            if (we_i)        cmd_o <= wb_i & CMD_KEEP;
            if (strb_n.load) ptr_o <= base_i;
        end
    end

    assert_cancel_idle_R3: assert property (@(posedge clk) disable iff (rst)
        strobe_o.cancel |-> !active_o);
    assert_load_base_R4: assert property (@(posedge clk) disable iff (rst)
        strobe_o.load |-> (ptr_o == $past(base_i)));
    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({strobe_o.cancel, strobe_o.load}));
    assert_quiet_write_R2: assert property (@(posedge clk) disable iff (rst)
        (we_i && wb_i[0] == cmd_o[0]) |=> (!strobe_o.cancel && !strobe_o.load
                                          && active_o == $past(active_o)
                                          || $past(end_i)));
endmodule

// File: rtl/bmr_stat_irq.sv
module bmr_stat_irq
    import bmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we_i,
    input  logic [7:0] wb_i,
    input  logic       err_set_i,
    input  logic       drv_irq_i,
    output logic       err_o,
    output logic       irq_bit_o,
    output logic       irq_o
);
    logic line_q;
    logic rise;

    assign rise  = drv_irq_i && !line_q;
    assign irq_o = drv_irq_i;

    always_ff @(posedge clk) begin
        line_q <= drv_irq_i;
        if (rst) begin
            err_o     <= 1'b0;
            irq_bit_o <= 1'b0;
        end else begin
            if (err_set_i)                 err_o <= 1'b1;
            else if (we_i && wb_i[ST_ERR]) err_o <= 1'b0;
            if (rise)                      irq_bit_o <= 1'b1;
            else if (we_i && wb_i[ST_IRQ]) irq_bit_o <= 1'b0;
        end
    end

    assert_irq_latch_R8: assert property (@(posedge clk) disable iff (rst)
        rise |=> irq_bit_o);
    assert_irq_keep_R8: assert property (@(posedge clk) disable iff (rst)
        (!drv_irq_i && line_q && !(we_i && wb_i[ST_IRQ])) |=> (irq_bit_o == $past(irq_bit_o)));
    assert_err_set_R6: assert property (@(posedge clk) disable iff (rst)
        err_set_i |=> err_o);
endmodule

// File: rtl/bmr_base_reg.sv
module bmr_base_reg
    import bmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BASE_BYTES-1:0] we_i,
    input  logic [BASE_W-1:0] wb_i,
    output logic [BASE_W-1:0] base_o
);
    logic [BASE_W-1:0] merged;

    generate
        for (genvar b = 0; b < BASE_BYTES; b++) begin : g_byte
            assign merged[b*8 +: 8] = we_i[b] ? wb_i[b*8 +: 8] : base_o[b*8 +: 8];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) base_o <= '0;
        else     base_o <= {merged[BASE_W-1:2], 2'b00};
    end

    assert_base_align_R9: assert property (@(posedge clk) disable iff (rst)
        base_o[1:0] == 2'b00);
    assert_base_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (we_i == '0) |=> $stable(base_o));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import bmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [2:0]  bus_off,
    input  logic [1:0]  bus_size,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        walk_pending_i,
    input  logic        walk_end_i,
    input  logic        walk_err_i,
    output logic        walk_cancel_o,
    output logic        walk_load_o,
    output logic        walk_kick_o,
    output logic        walk_flush_o,
    output logic [31:0] walk_ptr_o,
    output logic        dir_o,
    input  logic        drv_irq_i,
    output logic        irq_o
);
    logic [LANES-1:0] lane_we;
    logic [IMG_W-1:0] lane_wb;
    logic [IMG_W-1:0] image;
    logic [7:0]       cmd_byte;
    logic             active, err_bit, irq_bit;
    logic [BASE_W-1:0] base;
    walk_strobe_t     strobe;

    assign image = {base, 8'h00, {5'b0, irq_bit, err_bit, active}, 8'h00, cmd_byte};

    bmr_lane_map u_lanes (
        .wr_i(bus_wr), .off_i(bus_off), .size_i(bus_size), .wdata_i(bus_wdata),
        .img_i(image), .we_o(lane_we), .wb_o(lane_wb), .rdata_o(bus_rdata)
    );

    bmr_cmd_ctrl u_cmd (
        .clk(clk), .rst(rst), .we_i(lane_we[CMD_LANE]),
        .wb_i(lane_wb[CMD_LANE*8 +: 8]), .base_i(base),
        .pending_i(walk_pending_i), .end_i(walk_end_i),
        .cmd_o(cmd_byte), .active_o(active), .strobe_o(strobe),
        .flush_o(walk_flush_o), .ptr_o(walk_ptr_o)
    );

    bmr_stat_irq u_stat (
        .clk(clk), .rst(rst), .we_i(lane_we[STAT_LANE]),
        .wb_i(lane_wb[STAT_LANE*8 +: 8]), .err_set_i(walk_err_i),
        .drv_irq_i(drv_irq_i), .err_o(err_bit), .irq_bit_o(irq_bit), .irq_o(irq_o)
    );

    bmr_base_reg u_base (
        .clk(clk), .rst(rst), .we_i(lane_we[BASE_LANE +: BASE_BYTES]),
        .wb_i(lane_wb[BASE_LANE*8 +: BASE_W]), .base_o(base)
    );

    assign walk_cancel_o = strobe.cancel;
    assign walk_load_o   = strobe.load;
    assign walk_kick_o   = strobe.kick;
    assign dir_o         = cmd_byte[3];

    assert_cmd_reserved_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_off == 3'd0) |-> ((bus_rdata[7:0] & 8'hF6) == 8'h00));
    assert_hole_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_off == 3'd1 && bus_size == 2'd0) |-> (bus_rdata == 32'h0));
    assert_kick_with_load_R5: assert property (@(posedge clk) disable iff (rst)
        walk_kick_o |-> (walk_load_o && active));
endmodule

// File: tb/test_dma_chan_regs.sv
`timescale 1ns/1ps
module test_dma_chan_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_off = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        walk_pending_i = 1'b0, walk_end_i = 1'b0, walk_err_i = 1'b0;
    logic        walk_cancel_o, walk_load_o, walk_kick_o, walk_flush_o, dir_o;
    logic [31:0] walk_ptr_o;
    logic        drv_irq_i = 1'b0;
    logic        irq_o;

    int n_chk = 0, n_bad = 0, cycles = 0;

    logic [7:0]  m_cmd;
    logic        m_act, m_err, m_irq;
    logic [31:0] m_base, m_ptr;
    logic        e_cancel, e_load, e_kick;

    always #2.5 clk = ~clk;

    dma_chan_regs i_dma_chan_regs (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cmd = 0; m_act = 0; m_err = 0; m_irq = 0; m_base = 0; m_ptr = 0;
    endtask

    function automatic logic [7:0] img_byte(input int idx);
        case (idx)
            0: return m_cmd;
            2: return {5'b0, m_irq, m_err, m_act};
            4, 5, 6, 7: return m_base[(idx-4)*8 +: 8];
            default: return 8'h00;
        endcase
    endfunction

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] exp_read(input int off, input logic [1:0] sz);
        logic [31:0] r = 0;
        for (int k = 0; k < nbytes(sz); k++)
            if (off + k < 8) r[k*8 +: 8] = img_byte(off + k);
        return r;
    endfunction

    task automatic do_read(input string req, input int off, input logic [1:0] sz);
        @(negedge clk);
        bus_off = 3'(off); bus_size = sz;
        #1 check(req, bus_rdata, exp_read(off, sz));
    endtask

    task automatic do_write(input string req, input int off, input logic [1:0] sz,
                            input logic [31:0] data);
        e_cancel = 0; e_load = 0; e_kick = 0;
        for (int k = 0; k < nbytes(sz); k++) begin
            int l = off + k;
            logic [7:0] d = data[k*8 +: 8];
            if (l == 0) begin
                if (d[0] != m_cmd[0]) begin
                    if (!d[0]) begin e_cancel = 1; m_act = 0; end
                    else begin
                        e_load = 1; m_ptr = m_base;
                        if (!m_act) begin m_act = 1; e_kick = walk_pending_i; end
                    end
                end
                m_cmd = d & 8'h09;
            end else if (l == 2) begin
                if (d[1]) m_err = 0;
                if (d[2]) m_irq = 0;
            end else if (l >= 4 && l < 8) begin
                m_base[(l-4)*8 +: 8] = d;
            end
        end
        m_base[1:0] = 2'b00;
        @(negedge clk);
        bus_wr = 1; bus_off = 3'(off); bus_size = sz; bus_wdata = data;
        @(negedge clk);
        bus_wr = 0;
        check({req, " cancel R3"}, 32'(walk_cancel_o), 32'(e_cancel));
        check({req, " load R4"}, 32'(walk_load_o), 32'(e_load));
        check({req, " kick R5"}, 32'(walk_kick_o), 32'(e_kick));
        check({req, " dir R1"}, 32'(dir_o), 32'(m_cmd[3]));
        if (e_load) check({req, " ptr R4"}, walk_ptr_o, m_ptr);
    endtask

    task automatic full_readback(input string req);
        for (int o = 0; o < 8; o++) do_read(req, o, 2'd0);
        do_read(req, 4, 2'd2);
        do_read(req, 6, 2'd2);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_bad++; n_chk++;
                $display("FAIL watchdog actual=%0d expected=<100000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        // R11: reset state
        repeat (2) @(negedge clk);
        check("R11 flush in reset", 32'(walk_flush_o), 1);
        check("R11 cancel idle", 32'(walk_cancel_o), 0);
        rst = 0;
        @(negedge clk);
        check("R11 flush drops", 32'(walk_flush_o), 0);
        full_readback("R11 zero regs R10");

        // R9: base lanes and forced low bits
        do_write("R9 word", 4, 2'd2, 32'h1234_5677);
        do_read("R9 base word", 4, 2'd2);
        do_write("R9 byte lane", 6, 2'd0, 32'hFFFF_FFAB);
        do_write("R9 half low", 4, 2'd1, 32'h0000_C0DF);
        full_readback("R9 readback");
        // R10: read past the end
        do_read("R10 overrun", 7, 2'd2);
        do_read("R10 hole", 1, 2'd1);

        // R1/R4/R5: start rise with pending
        walk_pending_i = 1;
        do_write("R5 start pend", 0, 2'd0, 32'h0000_00FF);
        do_read("R1 cmd mask", 0, 2'd0);
        do_read("R7 active", 2, 2'd0);
        // R2: same start, direction change only
        do_write("R2 same start", 0, 2'd0, 32'h0000_0001);
        // R3: stop
        do_write("R3 stop", 0, 2'd2, 32'h0000_0008);
        do_read("R3 inactive R7", 2, 2'd0);
        // R4/R5: start without pending
        walk_pending_i = 0;
        do_write("R4 start", 0, 2'd0, 32'h0000_0001);
        // R6: walker end, error
        @(negedge clk); walk_end_i = 1; m_act = 0;
        @(negedge clk); walk_end_i = 0; walk_err_i = 1; m_err = 1;
        @(negedge clk); walk_err_i = 0;
        do_read("R6 end err", 2, 2'd0);
        // R7: bit 0 not writable, W1C of error
        do_write("R7 w1c err", 2, 2'd0, 32'h0000_0003);
        do_read("R7 status", 0, 2'd2);

        // R8: interrupt rise, pass-through, fall keeps bit
        @(negedge clk); drv_irq_i = 1;
        #1 check("R8 passthrough high", 32'(irq_o), 1);
        m_irq = 1;
        @(negedge clk); drv_irq_i = 0;
        #1 check("R8 passthrough low", 32'(irq_o), 0);
        do_read("R8 bit kept", 2, 2'd0);
        do_write("R7 w1c irq", 2, 2'd0, 32'h0000_0004);
        do_read("R7 irq cleared", 2, 2'd0);
        // R8: rise in the same cycle as a clear -> set wins
        @(negedge clk);
        drv_irq_i = 1; bus_wr = 1; bus_off = 3'd2; bus_size = 2'd0; bus_wdata = 32'h4;
        @(negedge clk); bus_wr = 0; m_irq = 1;
        do_read("R8 set beats clear", 2, 2'd0);
        @(negedge clk); drv_irq_i = 0;

        // random mix
        for (int it = 0; it < 600; it++) begin
            int op = $urandom_range(0, 5);
            case (op)
                0, 1: do_write("rand write", $urandom_range(0, 7),
                               2'($urandom_range(0, 3)), $urandom());
                2: do_read("rand read R10", $urandom_range(0, 7), 2'($urandom_range(0, 3)));
                3: begin
                    @(negedge clk); drv_irq_i = ~drv_irq_i;
                    if (drv_irq_i) m_irq = 1;
                    #1 check("rand irq R8", 32'(irq_o), 32'(drv_irq_i));
                end
                4: begin
                    @(negedge clk); walk_end_i = 1; m_act = 0;
                    @(negedge clk); walk_end_i = 0;
                end
                default: walk_pending_i = 1'($urandom_range(0, 1));
            endcase
        end
        full_readback("rand final");

        // R11: reset while active issues a cancel
        @(negedge clk); drv_irq_i = 0;
        if (m_cmd[0]) do_write("R11 prep stop", 0, 2'd0, 32'h0);
        do_write("R11 prep start", 0, 2'd0, 32'h1);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        check("R11 cancel on reset", 32'(walk_cancel_o), 1);
        check("R11 flush on reset", 32'(walk_flush_o), 1);
        model_reset();
        @(negedge clk);
        check("R11 cancel once", 32'(walk_cancel_o), 0);
        full_readback("R11 cleared");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule